// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block holds the configuration registers of a 32-bit PCI target. A separate bus core runs the protocol and hands it decoded configuration writes with their data. It also supplies a dword index that selects the register returned on the read path. The identification, revision and class registers are fixed by parameters. The command register, the status error flags and one 32-bit memory base address register can be changed at run time.

The command bits that other logic needs are driven out live. The two access enables go to the address decoder. Bit 6 (parity error response) and bit 8 (system error enable) go to the bus core. The bus core reports a detected parity error or a signalled system error with a one-cycle pulse, and the matching status flag then stays set until software clears it.

Top module: `pci_cfg_regs`

## Requirements
- R1: A register changes only on a rising clock edge where `cfg_wr` and `data_adv` are both high. If either is low, no register changes.
- R2: Byte enables are active low. `be_n[i]` = 0 lets lane i (`wdata[8i+7:8i]`) update the addressed register, and `be_n[i]` = 1 leaves that lane unchanged.
- R3: The command/status dword has index 1. Its bit 0 is IO access enable, driven on `io_en`, and its bit 1 is memory access enable, driven on `mem_en`. Of command bits 0 to 15, only bits 0, 1, 6 and 8 are writable, and all the other command bits read 0.
- R4: Command bit 6 is driven on `cmd_perr_resp` and command bit 8 is driven on `cmd_serr_en`, both from the cycle after the write.
- R5: A high `perr_pulse` on a clock edge sets status bit 15 (bit 31 of dword 1).
- R6: A high `serr_pulse` on a clock edge sets status bit 14 (bit 30 of dword 1).
- R7: A configuration write to dword 1 with lane 3 enabled clears each status error flag whose data bit is 1, and leaves a flag unchanged where the data bit is 0. If the set pulse for a flag is high in the same cycle as its clear, the flag ends up set.
- R8: Dword 0 reads {device ID, vendor ID}, dword 2 reads {class code, revision ID} and dword 11 reads {subsystem ID, subsystem vendor ID}. All of these come from parameters, and writes to them have no effect.
- R9: The base address register has index 4. Bits [31:BAR_SIZE_LOG2] are writable, and all bits below BAR_SIZE_LOG2 read 0, so bit 0 = 0 marks memory space. The stored value is driven on `bar_base`.
- R10: A read of any dword index other than 0, 1, 2, 4 and 11 returns 0, and writes to those indexes have no effect.
- R11: While `rst_n` is low, the command register, both status flags and the base address register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write transaction in progress |
| data_adv | input | 1 | Data phase completes this cycle |
| dw_addr | input | 6 | Dword index of the register to write and to read |
| be_n | input | 4 | Active-low byte enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `dw_addr` (combinational) |
| perr_pulse | input | 1 | Parity error detected, one-cycle pulse |
| serr_pulse | input | 1 | System error signalled, one-cycle pulse |
| io_en | output | 1 | Command bit 0 |
| mem_en | output | 1 | Command bit 1 |
| cmd_perr_resp | output | 1 | Command bit 6 |
| cmd_serr_en | output | 1 | Command bit 8 |
| bar_base | output | 32 | Current base address register value |

## Verification
The bench builds the block with BAR_SIZE_LOG2 = 8, so the writable base-address field begins in lane 1. A lane-3-only write then shows the merge of old and new bytes within the field, next to a read-only low byte. The bench also sets every ID parameter to a value that is distinct from the others and not symmetric, so a swapped halfword or byte in any ID dword gives a read mismatch. With these values the set-versus-clear collision on the status flags and the write qualification are each checked on their own cycle.

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs #(
  parameter logic [15:0] VENDOR_ID        = 16'h1B5E,
  parameter logic [15:0] DEVICE_ID        = 16'h0A31,
  parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h1B5E,
  parameter logic [15:0] SUBSYS_ID        = 16'h0001,
  parameter logic [7:0]  REVISION_ID      = 8'h02,
  parameter logic [23:0] CLASS_CODE       = 24'h118000,
  parameter int          BAR_SIZE_LOG2    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        data_adv,
  input  logic [5:0]  dw_addr,
  input  logic [3:0]  be_n,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        perr_pulse,
  input  logic        serr_pulse,
  output logic        io_en,
  output logic        mem_en,
  output logic        cmd_perr_resp,
  output logic        cmd_serr_en,
  output logic [31:0] bar_base
);
  localparam logic [5:0]  IDX_ID     = 6'd0;
  localparam logic [5:0]  IDX_CMDSTS = 6'd1;
  localparam logic [5:0]  IDX_CLASS  = 6'd2;
  localparam logic [5:0]  IDX_BAR    = 6'd4;
  localparam logic [5:0]  IDX_SUBSYS = 6'd11;
  localparam logic [31:0] BAR_MASK   = ~((32'd1 << BAR_SIZE_LOG2) - 32'd1);

  logic        wr_stb;
  logic [3:0]  lane_on;
  logic        hit_cs, hit_bar;
  logic        par_det_q, sys_sig_q;
  logic        clr_par, clr_sys;
  logic [31:0] bar_q;
  logic [15:0] cmd_word, sts_word;

  assign wr_stb  = cfg_wr & data_adv;
  assign lane_on = ~be_n;
  assign hit_cs  = wr_stb & (dw_addr == IDX_CMDSTS);
  assign hit_bar = wr_stb & (dw_addr == IDX_BAR);
  assign clr_par = hit_cs & lane_on[3] & wdata[31];
  assign clr_sys = hit_cs & lane_on[3] & wdata[30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_en         <= 1'b0;
      mem_en        <= 1'b0;
      cmd_perr_resp <= 1'b0;
      cmd_serr_en   <= 1'b0;
    end else if (hit_cs) begin
      if (lane_on[0]) begin
        io_en         <= wdata[0];
        mem_en        <= wdata[1];
        cmd_perr_resp <= wdata[6];
      end
      if (lane_on[1]) cmd_serr_en <= wdata[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_det_q <= 1'b0;
      sys_sig_q <= 1'b0;
    end else begin
      par_det_q <= perr_pulse | (par_det_q & ~clr_par);
      sys_sig_q <= serr_pulse | (sys_sig_q & ~clr_sys);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q <= '0;
    end else if (hit_bar) begin
      for (int i = 0; i < 4; i++)
        if (lane_on[i]) bar_q[8*i +: 8] <= wdata[8*i +: 8] & BAR_MASK[8*i +: 8];
    end
  end

  assign bar_base = bar_q;
  assign cmd_word = {7'd0, cmd_serr_en, 1'b0, cmd_perr_resp, 4'd0, mem_en, io_en};
  assign sts_word = {par_det_q, sys_sig_q, 14'd0};

  always_comb begin
    case (dw_addr)
      IDX_ID:     rdata = {DEVICE_ID, VENDOR_ID};
      IDX_CMDSTS: rdata = {sts_word, cmd_word};
      IDX_CLASS:  rdata = {CLASS_CODE, REVISION_ID};
      IDX_BAR:    rdata = bar_q;
      IDX_SUBSYS: rdata = {SUBSYS_ID, SUBSYS_VENDOR_ID};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/pci_cfg_regs_chk.sv
module pci_cfg_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        data_adv,
  input logic [5:0]  dw_addr,
  input logic [3:0]  be_n,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        perr_pulse,
  input logic        serr_pulse,
  input logic        io_en,
  input logic        mem_en,
  input logic        cmd_perr_resp,
  input logic        cmd_serr_en,
  input logic        par_det,
  input logic        sys_sig
);
  logic wr_cs, clr31, clr30;
  assign wr_cs = cfg_wr && data_adv && dw_addr == 6'd1;
  assign clr31 = wr_cs && !be_n[3] && wdata[31];
  assign clr30 = wr_cs && !be_n[3] && wdata[30];

  p_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && data_adv) |=> $stable({io_en, mem_en, cmd_perr_resp, cmd_serr_en}));

  p_lane0_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cs && be_n[0]) |=> $stable({io_en, mem_en, cmd_perr_resp}));

  p_cmd_export_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cs && !be_n[1]) |=> (cmd_serr_en == $past(wdata[8])));

  p_perr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    perr_pulse |=> par_det);

  p_serr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |=> sys_sig);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr31 && !perr_pulse) |=> !par_det);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_sig && !clr30) |=> sys_sig);

  p_bar_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_addr == 6'd4) |-> (rdata[3:0] == 4'd0));

  p_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dw_addr inside {6'd0, 6'd1, 6'd2, 6'd4, 6'd11}) |-> (rdata == 32'd0));
endmodule

bind pci_cfg_regs pci_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .data_adv(data_adv),
  .dw_addr(dw_addr), .be_n(be_n), .wdata(wdata), .rdata(rdata),
  .perr_pulse(perr_pulse), .serr_pulse(serr_pulse),
  .io_en(io_en), .mem_en(mem_en), .cmd_perr_resp(cmd_perr_resp),
  .cmd_serr_en(cmd_serr_en), .par_det(par_det_q), .sys_sig(sys_sig_q)
);

// File: tb/pci_cfg_regs_bench.sv
module pci_cfg_regs_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] VEN  = 16'hC0DE;
  localparam logic [15:0] DEV  = 16'h5A03;
  localparam logic [15:0] SVEN = 16'hBEEF;
  localparam logic [15:0] SID  = 16'h0042;
  localparam logic [7:0]  REV  = 8'h07;
  localparam logic [23:0] CLS  = 24'h048000;
  localparam int          NVEC = 11;
  // {wr, adv, waddr[6], be_n[4], wdata[32], raddr[6], expect[32]}
  localparam logic [81:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 6'd1,  4'h0, 32'hFFFF_FFFF, 6'd1,  32'h0000_0143},
    {1'b1, 1'b1, 6'd1,  4'hE, 32'h0000_0000, 6'd1,  32'h0000_0100},
    {1'b1, 1'b0, 6'd1,  4'h0, 32'h0000_0000, 6'd1,  32'h0000_0100},
    {1'b0, 1'b1, 6'd1,  4'h0, 32'h0000_0000, 6'd1,  32'h0000_0100},
    {1'b1, 1'b1, 6'd4,  4'h0, 32'hFFFF_FFFF, 6'd4,  32'hFFFF_FF00},
    {1'b1, 1'b1, 6'd4,  4'h7, 32'h1234_5678, 6'd4,  32'h12FF_FF00},
    {1'b1, 1'b1, 6'd0,  4'h0, 32'hFFFF_FFFF, 6'd0,  {DEV, VEN}},
    {1'b0, 1'b0, 6'd0,  4'hF, 32'h0000_0000, 6'd2,  {CLS, REV}},
    {1'b1, 1'b1, 6'd11, 4'h0, 32'h0000_0000, 6'd11, {SID, SVEN}},
    {1'b1, 1'b1, 6'd7,  4'h0, 32'hFFFF_FFFF, 6'd7,  32'h0000_0000},
    {1'b1, 1'b1, 6'd63, 4'h0, 32'hFFFF_FFFF, 6'd63, 32'h0000_0000}
  };

  function automatic string vec_req(input int i);
    case (i)
      0: return "R3";  1: return "R2";  2: return "R1";  3: return "R1";
      4: return "R9";  5: return "R2";  6: return "R8";  7: return "R8";
      8: return "R8";  default: return "R10";
    endcase
  endfunction

  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0, data_adv = 0, perr_pulse = 0, serr_pulse = 0;
  logic [5:0]  dw_addr = '0;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, bar_base;
  logic        io_en, mem_en, cmd_perr_resp, cmd_serr_en;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_regs #(
    .VENDOR_ID(VEN), .DEVICE_ID(DEV), .SUBSYS_VENDOR_ID(SVEN), .SUBSYS_ID(SID),
    .REVISION_ID(REV), .CLASS_CODE(CLS), .BAR_SIZE_LOG2(8)
  ) u_pci_cfg_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .data_adv(data_adv),
    .dw_addr(dw_addr), .be_n(be_n), .wdata(wdata), .rdata(rdata),
    .perr_pulse(perr_pulse), .serr_pulse(serr_pulse), .io_en(io_en),
    .mem_en(mem_en), .cmd_perr_resp(cmd_perr_resp), .cmd_serr_en(cmd_serr_en),
    .bar_base(bar_base)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic adv, input logic [5:0] a,
                       input logic [3:0] be, input logic [31:0] d,
                       input logic pe, input logic se);
    @(negedge clk);
    cfg_wr = wr; data_adv = adv; dw_addr = a; be_n = be; wdata = d;
    perr_pulse = pe; serr_pulse = se;
    @(posedge clk);
    #1;
    cfg_wr = 0; data_adv = 0; be_n = 4'hF; perr_pulse = 0; serr_pulse = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    dw_addr = a;
    #1;
    v = rdata;
  endtask

  task automatic reset_checks();
    logic [31:0] v;
    rd(6'd1, v); chk("R11 cmd/status", v, 32'h0);
    rd(6'd4, v); chk("R11 bar", v, 32'h0);
    chk("R11 exports", {28'd0, io_en, mem_en, cmd_perr_resp, cmd_serr_en}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    reset_checks();
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][81], VEC[i][80], VEC[i][79:74], VEC[i][73:70], VEC[i][69:38], 0, 0);
      rd(VEC[i][37:32], v);
      chk(vec_req(i), v, VEC[i][31:0]);
    end
    chk("R9 bar_base port", bar_base, 32'h12FF_FF00);

    // R3/R4 live exports
    cycle(1, 1, 6'd1, 4'hC, 32'h0000_0143, 0, 0);
    chk("R4 exports all", {28'd0, io_en, mem_en, cmd_perr_resp, cmd_serr_en}, 32'hF);
    cycle(1, 1, 6'd1, 4'hC, 32'h0000_0002, 0, 0);
    chk("R3 mem only", {28'd0, io_en, mem_en, cmd_perr_resp, cmd_serr_en}, 32'h4);

    // R5/R6 pulses set status flags
    cycle(0, 0, 6'd1, 4'hF, 0, 1, 0);
    rd(6'd1, v); chk("R5 parity flag", v, 32'h8000_0002);
    cycle(0, 0, 6'd1, 4'hF, 0, 0, 1);
    rd(6'd1, v); chk("R6 system flag", v, 32'hC000_0002);

    // R7 write-one-to-clear on lane 3 only, command untouched
    cycle(1, 1, 6'd1, 4'h7, 32'h8000_0000, 0, 0);
    rd(6'd1, v); chk("R7 clear bit31", v, 32'h4000_0002);
    // R7 clear with lane 3 disabled has no effect
    cycle(1, 1, 6'd1, 4'hF, 32'hC000_0000, 0, 0);
    rd(6'd1, v); chk("R7 lane3 off", v, 32'h4000_0002);
    // R7 set wins over clear in the same cycle
    cycle(1, 1, 6'd1, 4'h7, 32'h4000_0000, 0, 1);
    rd(6'd1, v); chk("R7 set priority", v, 32'h4000_0002);
    cycle(1, 1, 6'd1, 4'h7, 32'h4000_0000, 0, 0);
    rd(6'd1, v); chk("R7 clear bit30", v, 32'h0000_0002);

    // R11 reset mid-run
    cycle(0, 0, 6'd1, 4'hF, 0, 1, 1);
    @(negedge clk); rst_n = 0;
    #1;
    reset_checks();
    rd(6'd1, v); chk("R11 flags", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule